// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Master

This block drives a two-wire serial memory bus as its only master and fetches bytes from a serial EEPROM. A command gives a 7-bit device address, an 8-bit word address and a byte count. The master sends the word address as a dummy write, issues a repeated start, re-addresses the device for reading and then clocks in the requested bytes one after another. Each byte arrives on a one-cycle strobe. A missing acknowledge from the memory ends the transfer and sets an error flag.

The serial clock comes from a counter on the system clock. A select input picks the division ratio, either 8 or 512, when a command is accepted. Every bit slot is split into four equal quarters. SCL is low in the first two quarters and high in the last two. SDA is open-drain: the block only pulls it low through an output enable and reads the wired level on a separate input. The word address pointer inside the memory advances by itself, so a multi-byte read continues from one address to the next until the master refuses the last byte.

Top module: `twi_rd_master`

## Requirements
- R1: After reset, and whenever no command is running, `scl_o` is 1, `sda_oe` is 0 and `cmd_ready` is 1.
- R2: With `div_sel` = 0 one SCL period lasts 8 system clocks, and with `div_sel` = 1 it lasts 512. SCL is high for half of each period.
- R3: `div_sel` is taken only in the cycle a command is accepted. Changing it during a transfer does not alter the SCL period of that transfer.
- R4: A transfer opens with a start (SDA falls while SCL is high) and closes with a stop (SDA rises while SCL is high). At any other time SDA changes only while SCL is low. A read therefore shows exactly two starts and one stop.
- R5: Every byte is shifted MSB first and followed by one acknowledge bit. The byte after each start holds the device address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read).
- R6: A read sends, in this order: device/write, word address, repeated start, device/read. A one-byte read spans 39 SCL periods from start to stop, so SCL rises 39 times between acceptance and `done`.
- R7: The block returns `cmd_len` bytes taken from consecutive memory addresses. The address wraps from 8'hFF to 8'h00. A `cmd_len` of 0 is treated as 1.
- R8: The master drives an acknowledge (SDA low) after every received byte except the last. It leaves SDA released after the last byte and then sends a stop.
- R9: If SDA is high in an acknowledge slot owned by the memory, the master sends a stop, raises `nack_err` and returns no further bytes. `nack_err` stays high until the next command is accepted, and that acceptance clears it.
- R10: `rd_valid` pulses for one cycle per received byte, with the byte on `rd_data`. `done` pulses for one cycle as the bus returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | SCL ratio select: 1 gives /512, 0 gives /8 |
| cmd_valid | input | 1 | Command request; accepted when `cmd_ready` is high |
| cmd_ready | output | 1 | High while the master is idle |
| cmd_dev | input | 7 | Device address |
| cmd_word | input | 8 | Starting word address |
| cmd_len | input | LEN_W | Number of bytes to read (0 means 1) |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled level of the SDA line |
| rd_valid | output | 1 | One-cycle strobe for each received byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse when a transfer has finished |
| nack_err | output | 1 | Set by a missing acknowledge from the memory |

## Verification
The bench uses the default parameters: DIV_FAST = 8, DIV_SLOW = 512 and LEN_W = 8. With the fast ratio a bit slot is only eight clocks long, so multi-byte reads, the address wrap at 8'hFF, the zero-length case and the refused-address case all run quickly. One full read at the slow ratio checks the 512-clock period. A further read turns `div_sel` over right after acceptance, which shows that the ratio is held for the whole transfer. A behavioural memory on the wired-AND line checks the bytes sent, the acknowledges from the master and the start/stop events.

// File: rtl/twi_rd_pkg.sv
package twi_rd_pkg;

    localparam int DEV_W  = 7;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    // kind of the current SCL period (one bit slot)
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_WACK,
        ST_RECV,
        ST_MACK,
        ST_STOP
    } slot_e;

    // which byte of the read sequence is in flight
    typedef enum logic [1:0] {
        SEG_DEVW,
        SEG_WORD,
        SEG_DEVR,
        SEG_DATA
    } seg_e;

endpackage

// File: rtl/twi_rd_phase.sv
module twi_rd_phase #(
    parameter int DIV_FAST = 8,
    parameter int DIV_SLOW = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slow,
    output logic [1:0] qtr,
    output logic       mid_hi,
    output logic       slot_end
);
    localparam int Q_FAST = DIV_FAST / 4;
    localparam int Q_SLOW = DIV_SLOW / 4;
    localparam int CW     = ($clog2(Q_SLOW) > 0) ? $clog2(Q_SLOW) : 1;
    localparam logic [CW-1:0] LIM_F = CW'(Q_FAST - 1);
    localparam logic [CW-1:0] LIM_S = CW'(Q_SLOW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    qtr;
    } tmr_t;

    tmr_t          tmr_q, tmr_d;
    logic [CW-1:0] lim;
    logic          last;

    always_comb begin
        lim   = slow ? LIM_S : LIM_F;
        last  = (tmr_q.cnt == lim);
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else if (last) begin
            tmr_d.cnt = '0;
            tmr_d.qtr = tmr_q.qtr + 2'd1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign qtr      = tmr_q.qtr;
    assign mid_hi   = run && last && (tmr_q.qtr == 2'd2);
    assign slot_end = run && last && (tmr_q.qtr == 2'd3);

    // R2: the quarter counter never runs past the selected ratio
    assert_cnt_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= lim);

    // R2: the timer is parked at zero whenever the bus is idle
    assert_park_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tmr_q.cnt == '0 && tmr_q.qtr == 2'd0));

endmodule

// File: rtl/twi_rd_shift.sv
module twi_rd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         in_bit,
    output logic [W-1:0] value
);
    logic [W-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (load)          sr_d = load_val;
        else if (shift_en) sr_d = {sr_q[W-2:0], in_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign value = sr_q;

    // R5: a load and a shift never collide in one cycle
    assert_one_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_en));

endmodule

// File: rtl/twi_rd_master.sv
module twi_rd_master
    import twi_rd_pkg::*;
#(
    parameter int DIV_FAST = 8,
    parameter int DIV_SLOW = 512,
    parameter int LEN_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_sel,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [BYTE_W-1:0] cmd_word,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              scl_o,
    output logic              sda_oe,
    input  logic              sda_i,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              done,
    output logic              nack_err
);
    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        slot_e             st;
        seg_e              seg;
        logic [BIT_W-1:0]  bitn;
        logic [LEN_W-1:0]  left;
        logic [DEV_W-1:0]  dev;
        logic [BYTE_W-1:0] word;
        logic              slow;
        logic              hold;
        logic              ack_bad;
        logic              err;
        logic              rvalid;
        logic [BYTE_W-1:0] rdata;
        logic              done;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic [1:0]        qtr;
    logic              mid_hi, slot_end;
    logic              sh_load, sh_shift, sh_in;
    logic [BYTE_W-1:0] sh_val, sr_val;
    logic              oe_slot;

    twi_rd_phase #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl_q.st != ST_IDLE),
        .slow     (ctl_q.slow),
        .qtr      (qtr),
        .mid_hi   (mid_hi),
        .slot_end (slot_end)
    );

    twi_rd_shift #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift_en (sh_shift),
        .in_bit   (sh_in),
        .value    (sr_val)
    );

    // line decode: SCL high in quarters 2 and 3, SDA kept through quarter 0
    always_comb begin
        unique case (ctl_q.st)
            ST_START: oe_slot = (qtr == 2'd3);
            ST_STOP:  oe_slot = (qtr != 2'd3);
            ST_SEND:  oe_slot = ~sr_val[BYTE_W-1];
            ST_MACK:  oe_slot = (ctl_q.left != ONE_LEFT);
            default:  oe_slot = 1'b0;
        endcase
        if (ctl_q.st == ST_IDLE) begin
            scl_o  = 1'b1;
            sda_oe = 1'b0;
        end else begin
            scl_o  = qtr[1];
            sda_oe = (qtr == 2'd0) ? ctl_q.hold : oe_slot;
        end
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        ctl_d.done   = 1'b0;
        sh_load      = 1'b0;
        sh_val       = '0;
        sh_shift     = 1'b0;
        sh_in        = 1'b0;
        if (ctl_q.st == ST_IDLE) begin
            ctl_d.hold = 1'b0;
            if (cmd_valid) begin
                ctl_d.st   = ST_START;
                ctl_d.seg  = SEG_DEVW;
                ctl_d.dev  = cmd_dev;
                ctl_d.word = cmd_word;
                ctl_d.left = (cmd_len == '0) ? ONE_LEFT : cmd_len;
                ctl_d.slow = div_sel;
                ctl_d.err  = 1'b0;
                ctl_d.bitn = '0;
            end
        end else begin
            if (mid_hi) begin
                if (ctl_q.st == ST_WACK) ctl_d.ack_bad = sda_i;
                if (ctl_q.st == ST_RECV) begin
                    sh_shift = 1'b1;
                    sh_in    = sda_i;
                end
            end
            if (slot_end) begin
                ctl_d.hold = sda_oe;
                unique case (ctl_q.st)
                    ST_START: begin
                        sh_load    = 1'b1;
                        sh_val     = {ctl_q.dev, ctl_q.seg == SEG_DEVR};
                        ctl_d.st   = ST_SEND;
                        ctl_d.bitn = '0;
                    end
                    ST_SEND: begin
                        if (ctl_q.bitn == LAST_BIT) begin
                            ctl_d.st = ST_WACK;
                        end else begin
                            sh_shift   = 1'b1;
                            ctl_d.bitn = ctl_q.bitn + BIT_W'(1);
                        end
                    end
                    ST_WACK: begin
                        if (ctl_q.ack_bad) begin
                            ctl_d.err = 1'b1;
                            ctl_d.st  = ST_STOP;
                        end else begin
                            ctl_d.bitn = '0;
                            unique case (ctl_q.seg)
                                SEG_DEVW: begin
                                    sh_load   = 1'b1;
                                    sh_val    = ctl_q.word;
                                    ctl_d.seg = SEG_WORD;
                                    ctl_d.st  = ST_SEND;
                                end
                                SEG_WORD: begin
                                    ctl_d.seg = SEG_DEVR;
                                    ctl_d.st  = ST_START;
                                end
                                default: begin
                                    ctl_d.seg = SEG_DATA;
                                    ctl_d.st  = ST_RECV;
                                end
                            endcase
                        end
                    end
                    ST_RECV: begin
                        if (ctl_q.bitn == LAST_BIT) begin
                            ctl_d.rvalid = 1'b1;
                            ctl_d.rdata  = sr_val;
                            ctl_d.st     = ST_MACK;
                        end else begin
                            ctl_d.bitn = ctl_q.bitn + BIT_W'(1);
                        end
                    end
                    ST_MACK: begin
                        if (ctl_q.left == ONE_LEFT) begin
                            ctl_d.st = ST_STOP;
                        end else begin
                            ctl_d.left = ctl_q.left - ONE_LEFT;
                            ctl_d.bitn = '0;
                            ctl_d.st   = ST_RECV;
                        end
                    end
                    default: begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cmd_ready = (ctl_q.st == ST_IDLE);
    assign rd_valid  = ctl_q.rvalid;
    assign rd_data   = ctl_q.rdata;
    assign done      = ctl_q.done;
    assign nack_err  = ctl_q.err;

    // R4: outside start and stop slots, SDA moves only with SCL low on both sides
    assert_sda_low_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && (ctl_q.st != ST_START) && (ctl_q.st != ST_STOP))
        |-> (!scl_o && !$past(scl_o)));

    // R3: the latched ratio holds for the whole transfer
    assert_ratio_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !$past(cmd_ready)) |-> $stable(ctl_q.slow));

    // R10: byte strobe lasts one cycle
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R1: completion leaves the bus released and the master ready
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && scl_o && !sda_oe));

    // R9: a refused acknowledge never coexists with a byte strobe
    assert_err_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nack_err |-> !rd_valid);

endmodule

// File: tb/tb_twi_rd_master.sv
module tb_twi_rd_master;
    localparam int DIV_FAST = 8;
    localparam int DIV_SLOW = 512;
    localparam int LEN_W    = 8;
    localparam int T_HALF   = 2;   // 4 time-unit period, read as 250 MHz

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_sel = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [6:0]       cmd_dev = '0;
    logic [7:0]       cmd_word = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic             scl_o, sda_oe, rd_valid, done, nack_err;
    logic [7:0]       rd_data;
    logic             sl_low = 1'b0;
    wire              sda_bus;

    assign sda_bus = ~(sda_oe | sl_low);

    always #T_HALF clk = ~clk;

    twi_rd_master #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_dev(cmd_dev), .cmd_word(cmd_word),
        .cmd_len(cmd_len), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_bus),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .nack_err(nack_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] memf(input logic [7:0] a);
        logic [7:0] m;
        m = a * 8'd37;
        return m ^ 8'hA5;
    endfunction

    // bus monitor and behavioural memory
    localparam logic [6:0] SL_DEV = 7'h50;
    int         rises, starts, stops, p_min, p_max, h_min, h_max;
    longint     t_rise;
    bit         have_rise;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         sl_st = 0;   // 0 idle, 1 addr, 2 word, 3 send, 4 wait restart
    int         sbit = 0;
    logic [7:0] shr = '0, tx = '0, ptr = '0;
    logic       rdir = 1'b0;
    int         acks, nacks, nlog, ncap;
    logic [7:0] lg [0:7];
    logic [7:0] cap [0:15];

    always @(scl_o or sda_bus) begin
        if (rst_n) begin
            if (scl_o !== p_scl) begin
                if (scl_o === 1'b1) begin
                    rises++;
                    if (have_rise) begin
                        int per;
                        per = int'(($time - t_rise) / (2 * T_HALF));
                        if (per < p_min) p_min = per;
                        if (per > p_max) p_max = per;
                    end
                    t_rise = $time;
                    have_rise = 1'b1;
                    if (sl_st == 1 || sl_st == 2) begin
                        if (sbit < 8) begin
                            shr = {shr[6:0], sda_bus};
                            sbit++;
                        end
                    end else if (sl_st == 3) begin
                        if (sbit < 8) sbit++;
                        else if (sda_bus === 1'b0) begin
                            acks++;
                            ptr = ptr + 8'd1;
                            tx = memf(ptr);
                            sbit = 0;
                        end else begin
                            nacks++;
                            sl_st = 0;
                        end
                    end
                end else if (scl_o === 1'b0) begin
                    if (have_rise) begin
                        int hi;
                        hi = int'(($time - t_rise) / (2 * T_HALF));
                        if (hi < h_min) h_min = hi;
                        if (hi > h_max) h_max = hi;
                    end
                    if (sl_st == 1 || sl_st == 2) begin
                        if (sbit == 8) begin
                            if (nlog < 8) lg[nlog] = shr;
                            nlog++;
                            if (sl_st == 2) begin
                                ptr = shr;
                                sl_low = 1'b1;
                                sbit = 9;
                            end else if (shr[7:1] == SL_DEV) begin
                                rdir = shr[0];
                                sl_low = 1'b1;
                                sbit = 9;
                            end else begin
                                sl_st = 0;
                            end
                        end else if (sbit == 9) begin
                            sl_low = 1'b0;
                            sbit = 0;
                            if (sl_st == 2) sl_st = 4;
                            else if (rdir) begin
                                sl_st = 3;
                                tx = memf(ptr);
                                sl_low = ~tx[7];
                            end else sl_st = 2;
                        end
                    end else if (sl_st == 3) begin
                        if (sbit < 8) sl_low = ~tx[7 - sbit];
                        else sl_low = 1'b0;
                    end else begin
                        sl_low = 1'b0;
                    end
                end
            end else if (sda_bus !== p_sda && scl_o === 1'b1) begin
                if (sda_bus === 1'b0) begin
                    starts++;
                    sl_st = 1;
                    sbit = 0;
                    sl_low = 1'b0;
                end else if (sda_bus === 1'b1) begin
                    stops++;
                    sl_st = 0;
                    sl_low = 1'b0;
                end
            end
        end
        p_scl = scl_o;
        p_sda = sda_bus;
    end

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (ncap < 16) cap[ncap] = rd_data;
            ncap++;
        end
    end

    task automatic do_read(input logic [6:0] dev, input logic [7:0] word,
                           input logic [7:0] len, input logic slow, input bit flip);
        bit got;
        rises = 0; starts = 0; stops = 0; have_rise = 1'b0;
        p_min = 1 << 30; p_max = 0; h_min = 1 << 30; h_max = 0;
        acks = 0; nacks = 0; nlog = 0; ncap = 0;
        @(negedge clk);
        div_sel = slow; cmd_dev = dev; cmd_word = word; cmd_len = len; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (flip) div_sel = ~slow;
        got = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            if (done) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk_eq("R10 done pulse seen", int'(got), 1);
        chk_eq("R1 idle scl after done", int'(scl_o), 1);
        chk_eq("R1 idle sda_oe after done", int'(sda_oe), 0);
    endtask

    task automatic t_reset;
        chk_eq("R1 reset scl_o", int'(scl_o), 1);
        chk_eq("R1 reset sda_oe", int'(sda_oe), 0);
        chk_eq("R1 reset cmd_ready", int'(cmd_ready), 1);
        chk_eq("R10 reset rd_valid", int'(rd_valid), 0);
        chk_eq("R9 reset nack_err", int'(nack_err), 0);
    endtask

    task automatic t_single_fast;
        do_read(SL_DEV, 8'h23, 8'd1, 1'b0, 1'b0);
        chk_eq("R6 scl rises one byte", rises, 39);
        chk_eq("R7 byte count", ncap, 1);
        chk_eq("R7 data", int'(cap[0]), int'(memf(8'h23)));
        chk_eq("R4 starts", starts, 2);
        chk_eq("R4 stops", stops, 1);
        chk_eq("R5 first byte dev+write", int'(lg[0]), int'({SL_DEV, 1'b0}));
        chk_eq("R6 second byte word", int'(lg[1]), 8'h23);
        chk_eq("R5 third byte dev+read", int'(lg[2]), int'({SL_DEV, 1'b1}));
        chk_eq("R2 fast period min", p_min, 8);
        chk_eq("R2 fast period max", p_max, 8);
        chk_eq("R2 fast high time", h_max, 4);
        chk_eq("R8 final nack", nacks, 1);
        chk_eq("R9 no error", int'(nack_err), 0);
    endtask

    task automatic t_seq_wrap;
        do_read(SL_DEV, 8'hFE, 8'd4, 1'b0, 1'b0);
        chk_eq("R7 seq count", ncap, 4);
        for (int k = 0; k < 4; k++)
            chk_eq("R7 seq data wrap", int'(cap[k]), int'(memf(8'hFE + 8'(k))));
        chk_eq("R8 master acks", acks, 3);
        chk_eq("R8 master nacks", nacks, 1);
        chk_eq("R6 scl rises four bytes", rises, 66);
    endtask

    task automatic t_len_zero;
        do_read(SL_DEV, 8'h07, 8'd0, 1'b0, 1'b0);
        chk_eq("R7 len zero count", ncap, 1);
        chk_eq("R7 len zero data", int'(cap[0]), int'(memf(8'h07)));
    endtask

    task automatic t_slow;
        do_read(SL_DEV, 8'h41, 8'd1, 1'b1, 1'b0);
        chk_eq("R2 slow period min", p_min, 512);
        chk_eq("R2 slow period max", p_max, 512);
        chk_eq("R2 slow high time", h_min, 256);
        chk_eq("R7 slow data", int'(cap[0]), int'(memf(8'h41)));
    endtask

    task automatic t_ratio_flip;
        do_read(SL_DEV, 8'h10, 8'd2, 1'b0, 1'b1);
        chk_eq("R3 period after flip min", p_min, 8);
        chk_eq("R3 period after flip max", p_max, 8);
        chk_eq("R3 data after flip", int'(cap[1]), int'(memf(8'h11)));
        div_sel = 1'b0;
    endtask

    task automatic t_no_ack;
        do_read(7'h51, 8'h30, 8'd2, 1'b0, 1'b0);
        chk_eq("R9 error raised", int'(nack_err), 1);
        chk_eq("R9 no bytes", ncap, 0);
        chk_eq("R9 stop issued", stops, 1);
        chk_eq("R9 single start", starts, 1);
        chk_eq("R9 scl rises", rises, 11);
        repeat (20) @(negedge clk);
        chk_eq("R9 error held", int'(nack_err), 1);
    endtask

    task automatic t_err_clear;
        do_read(SL_DEV, 8'h80, 8'd1, 1'b0, 1'b0);
        chk_eq("R9 error cleared", int'(nack_err), 0);
        chk_eq("R9 data after clear", int'(cap[0]), int'(memf(8'h80)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R10: got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single_fast();
        t_seq_wrap();
        t_len_zero();
        t_slow();
        t_ratio_flip();
        t_no_ack();
        t_err_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule